// File: doc/BRIEF.md
# Lockstep SIMD Processing-Element Array with Torus Shifts

The block is a grid of identical processing elements (PEs), ROWS by COLS (2x2 by default, sized up to 8x8), that all execute the same instruction in the same cycle. A host drives one instruction word per cycle onto a shared broadcast port. Each PE holds a small register file, an adder/subtractor, a zero flag, a user status flag, a sticky error bit and a small stack of saved enable bits. Register 0 is hard-wired to zero.

Data moves between PEs only through explicit transfer instructions. One transfer copies a register from every PE's neighbour into every PE in the same cycle, along wraparound links in one of four directions. There is no routing, no queueing and no arbitration: the instruction stream alone decides what moves where. Conditional work uses the enable stack. A subtract sets each PE's zero flag, a push narrows the enable set to the PEs whose flag is set, and a pop restores the enable set in force before the push. PEs that are not enabled change no register or flag and offer no store data. Each PE's user flag and error bit are ORed across the array into one status bit for the host.

Instructions enter on a valid/ready port. The array accepts any non-store word in the cycle it is offered. A store word offers each enabled PE's value on a result stream that shares one ready input. The store word is held, with ready low, until that ready is high, and the host must keep the word stable while it waits.

Top module: `simd_torus_array`

## Requirements
- R1: After a synchronous active-high reset every register of every PE reads 0, every PE is enabled (a store yields a valid word from each PE), the enable stack is empty, and `flag_any` is 0.
- R2: The instruction word holds, from bit 0 up: opcode [3:0], rd [6:4], ra [9:7], rb [12:10], an 8-bit zero-extended immediate [20:13] and a direction [22:21]. In every enabled PE, ADD (1) writes ra+rb, SUB (2) writes ra-rb, MOVI (3) writes the immediate, ADDI (4) writes ra+immediate and MOV (5) writes ra, all modulo 2^DW. The result is visible to the next instruction. Code 0 is a no-operation.
- R3: Register 0 always reads 0. Writes to it are discarded.
- R4: GETID (10) writes the PE's index, row*COLS+col, into rd.
- R5: XFER (6) writes rd of every enabled PE with ra read from a neighbour, with wraparound at the edges. Direction 0 (north) takes from row+1, 1 (south) from row-1, 2 (east) from col-1, and 3 (west) from col+1. COLS east transfers return each value to its origin.
- R6: SUB also sets the zero flag of each enabled PE to (result==0). PUSHEQ (7) saves the enable bit on the stack and then ANDs it with the zero flag. Disabled PEs write no register, change no flag and raise no store valid.
- R7: POPM (8) restores the enable bit saved by the matching PUSHEQ. Nested push/pop pairs restore the enable set in last-in, first-out order.
- R8: The stack holds MASK_DEPTH (4) entries. A PUSHEQ on a full stack or a POPM on an empty one sets a sticky error bit in every PE and leaves the enable bits and stack unchanged. Only reset clears the error.
- R9: SETF (11) sets each enabled PE's user flag to (ra != 0). `flag_any` is the OR, across all PEs, of user flag and error bit, valid in the cycle after the instruction is accepted.
- R10: STORE (9) raises `st_valid[i]` for each enabled PE i while the word is offered, with `st_data` slice i carrying that PE's ra. When `st_ready` is low, `ins_ready` is low for a store word and high for any other word.
- R11: A row-then-column all-reduce made only of XFER, ADD and MOV leaves the sum of all PEs' starting values in every PE. With starting values 1..4 on a 2x2 array, every PE ends at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Broadcast instruction word is offered |
| ins_ready | output | 1 | Array accepts the offered word this cycle |
| ins_data | input | 4+3*REGW+10 (23) | Broadcast instruction word |
| st_valid | output | ROWS*COLS | Per-PE store word valid |
| st_ready | input | 1 | Host accepts store words this cycle |
| st_data | output | ROWS*COLS*DW | Per-PE store data, PE i in slice i |
| flag_any | output | 1 | OR of all PE user flags and error bits |

## Verification
The bench sweeps operand pairs across every PE, including differences that wrap below zero. A wrong carry or a dropped immediate shows up as a wrong per-PE sum. Every transfer direction is checked against neighbour indices worked out arithmetically, so a swapped direction or a missing wraparound returns the wrong PE's index. Mask tests check nested pushes, where a wrong pop would re-enable too many PEs, and a subtract issued while PEs are masked, which a flawed design would let set the masked PEs' zero flags and so widen a later push. Stack overflow and underflow must raise the shared status bit without disturbing enables, and a stalled store must hold back ready only for store words.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int OPW  = 4;
  localparam int IMMW = 8;
  localparam int DIRW = 2;

  typedef enum logic [OPW-1:0] {
    OP_NOP    = 4'd0,
    OP_ADD    = 4'd1,
    OP_SUB    = 4'd2,
    OP_MOVI   = 4'd3,
    OP_ADDI   = 4'd4,
    OP_MOV    = 4'd5,
    OP_XFER   = 4'd6,
    OP_PUSHEQ = 4'd7,
    OP_POPM   = 4'd8,
    OP_STORE  = 4'd9,
    OP_GETID  = 4'd10,
    OP_SETF   = 4'd11
  } op_e;

  typedef enum logic [DIRW-1:0] {
    DIR_N = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2,
    DIR_W = 2'd3
  } dir_e;
endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
#(
  parameter int REGW = 3,
  localparam int INS_W = OPW + 3*REGW + IMMW + DIRW
) (
  input  logic [INS_W-1:0] word,
  output op_e              op,
  output logic [REGW-1:0]  rd,
  output logic [REGW-1:0]  ra,
  output logic [REGW-1:0]  rb,
  output logic [IMMW-1:0]  imm,
  output dir_e             dir
);
  localparam int RD_LO  = OPW;
  localparam int RA_LO  = RD_LO + REGW;
  localparam int RB_LO  = RA_LO + REGW;
  localparam int IMM_LO = RB_LO + REGW;
  localparam int DIR_LO = IMM_LO + IMMW;

  assign op  = op_e'(word[OPW-1:0]);
  assign rd  = word[RD_LO +: REGW];
  assign ra  = word[RA_LO +: REGW];
  assign rb  = word[RB_LO +: REGW];
  assign imm = word[IMM_LO +: IMMW];
  assign dir = dir_e'(word[DIR_LO +: DIRW]);
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NREGS = 8,
  parameter int DEPTH = 4,
  parameter int ID    = 0,
  localparam int REGW = $clog2(NREGS),
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  op_e             op,
  input  logic [REGW-1:0] rd,
  input  logic [REGW-1:0] ra,
  input  logic [REGW-1:0] rb,
  input  logic [IMMW-1:0] imm,
  input  logic [DW-1:0]   shift_in,
  output logic [DW-1:0]   ra_val,
  output logic            en_o,
  output logic            err_o,
  output logic            flag_o
);
  logic [DW-1:0]    rf [NREGS];
  logic [DW-1:0]    rb_val;
  logic [DW-1:0]    imm_ext;
  logic [DW-1:0]    res;
  logic             wr;
  logic             en;
  logic             zf;
  logic             uf;
  logic             err;
  logic [DEPTH-1:0] stk;
  logic [SPW-1:0]   sp;
  logic [SPW-1:0]   sp_dec;

  assign ra_val  = (ra == '0) ? '0 : rf[ra];
  assign rb_val  = (rb == '0) ? '0 : rf[rb];
  assign imm_ext = {{(DW-IMMW){1'b0}}, imm};
  assign sp_dec  = sp - SPW'(1);

  always_comb begin
    wr  = 1'b1;
    res = '0;
    case (op)
      OP_ADD:   res = ra_val + rb_val;
      OP_SUB:   res = ra_val - rb_val;
      OP_MOVI:  res = imm_ext;
      OP_ADDI:  res = ra_val + imm_ext;
      OP_MOV:   res = ra_val;
      OP_XFER:  res = shift_in;
      OP_GETID: res = DW'(ID);
      default:  wr  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREGS; k++) rf[k] <= '0;
      en  <= 1'b1;
      zf  <= 1'b0;
      uf  <= 1'b0;
      err <= 1'b0;
      stk <= '0;
      sp  <= '0;
    end else if (fire) begin
      if (wr && en && rd != '0) rf[rd] <= res;
      if (op == OP_SUB && en) zf <= (res == '0);
      if (op == OP_SETF && en) uf <= (ra_val != '0);
      if (op == OP_PUSHEQ) begin
        if (sp == SPW'(DEPTH)) begin
          err <= 1'b1;
        end else begin
          stk[sp[IDXW-1:0]] <= en;
          sp <= sp + SPW'(1);
          en <= en & zf;
        end
      end
      if (op == OP_POPM) begin
        if (sp == '0) begin
          err <= 1'b1;
        end else begin
          en <= stk[sp_dec[IDXW-1:0]];
          sp <= sp_dec;
        end
      end
    end
  end

  assign en_o   = en;
  assign err_o  = err;
  assign flag_o = uf | err;
endmodule

// File: rtl/simd_or_tree.sv
module simd_or_tree #(
  parameter int N = 4,
  localparam int LV = (N <= 1) ? 0 : $clog2(N),
  localparam int N2 = 1 << LV
) (
  input  logic [N-1:0] leaves,
  output logic         any
);
  logic [N2-1:0] lvl;

  always_comb begin
    lvl = '0;
    lvl[N-1:0] = leaves;
    for (int w = N2 / 2; w >= 1; w = w / 2) begin
      for (int j = 0; j < w; j++) lvl[j] = lvl[2*j] | lvl[2*j+1];
    end
    any = lvl[0];
  end
endmodule

// File: rtl/simd_torus_array.sv
module simd_torus_array
  import simd_pkg::*;
#(
  parameter int ROWS       = 2,
  parameter int COLS       = 2,
  parameter int DW         = 16,
  parameter int NREGS      = 8,
  parameter int MASK_DEPTH = 4,
  localparam int N     = ROWS * COLS,
  localparam int REGW  = $clog2(NREGS),
  localparam int INS_W = OPW + 3*REGW + IMMW + DIRW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [INS_W-1:0] ins_data,
  output logic [N-1:0]    st_valid,
  input  logic            st_ready,
  output logic [N*DW-1:0] st_data,
  output logic            flag_any
);
  op_e             op;
  dir_e            dir;
  logic [REGW-1:0] rd, ra, rb;
  logic [IMMW-1:0] imm;
  logic            is_store;
  logic            fire;
  logic [N*DW-1:0] rv_flat;
  logic [N-1:0]    en_vec;
  logic [N-1:0]    err_vec;
  logic [N-1:0]    flag_vec;

  simd_decode #(.REGW(REGW)) u_dec (
    .word(ins_data), .op(op), .rd(rd), .ra(ra), .rb(rb), .imm(imm), .dir(dir)
  );

  assign is_store  = (op == OP_STORE);
  assign ins_ready = !(is_store && !st_ready);
  assign fire      = ins_valid && ins_ready;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I    = r*COLS + c;
      localparam int FR_S = ((r + 1) % ROWS) * COLS + c;
      localparam int FR_N = ((r + ROWS - 1) % ROWS) * COLS + c;
      localparam int FR_W = r*COLS + (c + COLS - 1) % COLS;
      localparam int FR_E = r*COLS + (c + 1) % COLS;
      logic [DW-1:0] sh;

      always_comb begin
        case (dir)
          DIR_N:   sh = rv_flat[FR_S*DW +: DW];
          DIR_S:   sh = rv_flat[FR_N*DW +: DW];
          DIR_E:   sh = rv_flat[FR_W*DW +: DW];
          default: sh = rv_flat[FR_E*DW +: DW];
        endcase
      end

      simd_pe #(
        .DW(DW), .NREGS(NREGS), .DEPTH(MASK_DEPTH), .ID(I)
      ) u_pe (
        .clk(clk), .rst(rst), .fire(fire), .op(op),
        .rd(rd), .ra(ra), .rb(rb), .imm(imm), .shift_in(sh),
        .ra_val(rv_flat[I*DW +: DW]),
        .en_o(en_vec[I]), .err_o(err_vec[I]), .flag_o(flag_vec[I])
      );

      assign st_valid[I] = ins_valid & is_store & en_vec[I];
    end
  end

  assign st_data = rv_flat;

  simd_or_tree #(.N(N)) u_or (.leaves(flag_vec), .any(flag_any));
endmodule

// File: rtl/simd_torus_checker.sv
module simd_torus_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         ins_valid,
  input logic         ins_ready,
  input logic [N-1:0] st_valid,
  input logic         st_ready,
  input logic         flag_any,
  input logic [N-1:0] err_vec
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !flag_any); // R1
  AST_STALL_NEEDS_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !ins_ready) |-> !st_ready); // R10
  AST_STORE_WITH_INSN: assert property (@(posedge clk) disable iff (rst)
    (|st_valid) |-> ins_valid); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(err_vec) & ~err_vec) == '0)); // R8
  AST_ERR_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
    (err_vec == '0) || (err_vec == {N{1'b1}})); // R8
  AST_ERR_SEEN: assert property (@(posedge clk) disable iff (rst)
    (|err_vec) |-> flag_any); // R9
endmodule

bind simd_torus_array simd_torus_checker #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .st_valid(st_valid), .st_ready(st_ready), .flag_any(flag_any),
  .err_vec(err_vec)
);

// File: tb/tb_simd_torus_array.sv
`timescale 1ns/1ps
module tb_simd_torus_array;
  import simd_pkg::*;
  localparam int ROWS = 2, COLS = 2, DW = 16, NREGS = 8;
  localparam int N = ROWS * COLS;
  localparam int REGW = 3;
  localparam int INS_W = 23;

  logic clk = 0, rst = 1, ins_valid = 0, st_ready = 1, flag_any, ins_ready;
  logic [INS_W-1:0] ins_data = '0;
  logic [N-1:0] st_valid;
  logic [N*DW-1:0] st_data;
  int checks = 0, errors = 0;
  logic gv [N];
  int gd [N];

  simd_torus_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .NREGS(NREGS)) dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .flag_any(flag_any)
  );

  always #2.5 clk = ~clk;

  function automatic logic [INS_W-1:0] pack(input logic [3:0] op, input int rd,
      input int ra, input int rb, input int imm, input int dir);
    return {2'(dir), 8'(imm), REGW'(rb), REGW'(ra), REGW'(rd), op};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; ins_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic issue(input logic [3:0] op, input int rd, input int ra,
      input int rb, input int imm, input int dir);
    @(negedge clk);
    ins_valid = 1; ins_data = pack(op, rd, ra, rb, imm, dir);
    @(posedge clk); #1;
    ins_valid = 0; ins_data = '0;
  endtask

  task automatic grab(input int ra);
    @(negedge clk);
    ins_valid = 1; ins_data = pack(OP_STORE, 0, ra, 0, 0, 0);
    #1;
    for (int i = 0; i < N; i++) begin
      gv[i] = st_valid[i];
      gd[i] = int'(st_data[i*DW +: DW]);
    end
    @(posedge clk); #1;
    ins_valid = 0; ins_data = '0;
  endtask

  function automatic int nbr(input int i, input int d);
    int r, c;
    r = i / COLS; c = i % COLS;
    case (d)
      0: return ((r + 1) % ROWS) * COLS + c;
      1: return ((r + ROWS - 1) % ROWS) * COLS + c;
      2: return r * COLS + (c + COLS - 1) % COLS;
      default: return r * COLS + (c + 1) % COLS;
    endcase
  endfunction

  // r1 holds the starting values; result left in r2
  task automatic allreduce();
    issue(OP_MOV, 2, 1, 0, 0, 0);
    for (int k = 0; k < COLS - 1; k++) begin
      issue(OP_XFER, 1, 1, 0, 0, 2);
      issue(OP_ADD, 2, 2, 1, 0, 0);
    end
    issue(OP_MOV, 1, 2, 0, 0, 0);
    for (int k = 0; k < ROWS - 1; k++) begin
      issue(OP_XFER, 1, 1, 0, 0, 0);
      issue(OP_ADD, 2, 2, 1, 0, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int avals [4] = '{0, 1, 100, 255};
    int bvals [4] = '{0, 7, 200, 255};
    int e3, sum;
    do_reset();

    // R1: reset state
    chk("R1", "flag_any", flag_any, 0);
    for (int r = 1; r < NREGS; r++) begin
      grab(r);
      for (int i = 0; i < N; i++) begin
        chk("R1", "store valid", gv[i], 1);
        chk("R1", "reg zero", gd[i], 0);
      end
    end

    // R4: element index
    issue(OP_GETID, 1, 0, 0, 0, 0);
    grab(1);
    for (int i = 0; i < N; i++) chk("R4", "id", gd[i], i);

    // R3: register 0 stays zero
    issue(OP_MOVI, 0, 0, 0, 77, 0);
    issue(OP_ADDI, 0, 1, 0, 5, 0);
    grab(0);
    for (int i = 0; i < N; i++) chk("R3", "r0", gd[i], 0);

    // R2: arithmetic sweep
    foreach (avals[ai]) foreach (bvals[bi]) begin
      issue(OP_GETID, 1, 0, 0, 0, 0);
      issue(OP_MOVI, 2, 0, 0, bvals[bi], 0);
      issue(OP_ADDI, 3, 1, 0, avals[ai], 0);
      issue(OP_ADD, 4, 3, 2, 0, 0);
      issue(OP_SUB, 5, 2, 3, 0, 0);
      issue(OP_MOV, 6, 4, 0, 0, 0);
      grab(4);
      for (int i = 0; i < N; i++) chk("R2", "add", gd[i], i + avals[ai] + bvals[bi]);
      grab(5);
      for (int i = 0; i < N; i++) begin
        e3 = i + avals[ai];
        chk("R2", "sub wrap", gd[i], (bvals[bi] - e3) & 16'hFFFF);
      end
      grab(6);
      for (int i = 0; i < N; i++) chk("R2", "mov", gd[i], i + avals[ai] + bvals[bi]);
    end

    // R5: transfers in each direction
    issue(OP_GETID, 1, 0, 0, 0, 0);
    for (int d = 0; d < 4; d++) begin
      issue(OP_XFER, 2, 1, 0, 0, d);
      grab(2);
      for (int i = 0; i < N; i++) chk("R5", $sformatf("xfer dir %0d", d), gd[i], nbr(i, d));
    end
    issue(OP_MOV, 3, 1, 0, 0, 0);
    for (int k = 0; k < COLS; k++) issue(OP_XFER, 3, 3, 0, 0, 2);
    grab(3);
    for (int i = 0; i < N; i++) chk("R5", "full ring", gd[i], i);

    // R6 / R7: masking and nesting
    do_reset();
    issue(OP_GETID, 1, 0, 0, 0, 0);
    issue(OP_MOVI, 4, 0, 0, 7, 0);
    issue(OP_SUB, 3, 1, 0, 0, 0);
    issue(OP_PUSHEQ, 0, 0, 0, 0, 0);
    issue(OP_MOVI, 4, 0, 0, 99, 0);
    grab(4);
    for (int i = 0; i < N; i++) chk("R6", "store mask", gv[i], i == 0);
    chk("R6", "enabled write", gd[0], 99);
    issue(OP_PUSHEQ, 0, 0, 0, 0, 0);
    issue(OP_POPM, 0, 0, 0, 0, 0);
    grab(4);
    for (int i = 0; i < N; i++) chk("R7", "inner pop", gv[i], i == 0);
    issue(OP_POPM, 0, 0, 0, 0, 0);
    grab(4);
    for (int i = 0; i < N; i++) begin
      chk("R7", "outer pop", gv[i], 1);
      chk("R6", "masked no write", gd[i], (i == 0) ? 99 : 7);
    end
    issue(OP_SUB, 3, 1, 0, 0, 0);
    issue(OP_PUSHEQ, 0, 0, 0, 0, 0);
    issue(OP_SUB, 3, 0, 0, 0, 0);
    issue(OP_POPM, 0, 0, 0, 0, 0);
    issue(OP_PUSHEQ, 0, 0, 0, 0, 0);
    grab(4);
    for (int i = 0; i < N; i++) chk("R6", "masked zero flag kept", gv[i], i == 0);
    issue(OP_POPM, 0, 0, 0, 0, 0);
    chk("R6", "no error", flag_any, 0);

    // R8: overflow and underflow
    do_reset();
    issue(OP_SUB, 3, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) issue(OP_PUSHEQ, 0, 0, 0, 0, 0);
    chk("R8", "full stack no error", flag_any, 0);
    issue(OP_PUSHEQ, 0, 0, 0, 0, 0);
    chk("R8", "overflow error", flag_any, 1);
    grab(0);
    for (int i = 0; i < N; i++) chk("R8", "enable kept", gv[i], 1);
    for (int k = 0; k < 4; k++) issue(OP_POPM, 0, 0, 0, 0, 0);
    chk("R8", "sticky", flag_any, 1);
    do_reset();
    chk("R8", "cleared by reset", flag_any, 0);
    issue(OP_POPM, 0, 0, 0, 0, 0);
    chk("R8", "underflow error", flag_any, 1);
    grab(0);
    for (int i = 0; i < N; i++) chk("R8", "enable kept on underflow", gv[i], 1);

    // R9: user flags through the OR tree
    do_reset();
    issue(OP_GETID, 1, 0, 0, 0, 0);
    issue(OP_SETF, 0, 1, 0, 0, 0);
    chk("R9", "some flags", flag_any, 1);
    issue(OP_MOVI, 2, 0, 0, 0, 0);
    issue(OP_SETF, 0, 2, 0, 0, 0);
    chk("R9", "flags cleared", flag_any, 0);
    issue(OP_MOVI, 2, 0, 0, N - 1, 0);
    issue(OP_SUB, 3, 1, 2, 0, 0);
    issue(OP_PUSHEQ, 0, 0, 0, 0, 0);
    issue(OP_SETF, 0, 1, 0, 0, 0);
    chk("R9", "single far element", flag_any, 1);
    issue(OP_POPM, 0, 0, 0, 0, 0);
    issue(OP_SETF, 0, 0, 0, 0, 0);
    chk("R9", "all clear", flag_any, 0);

    // R10: store back-pressure
    do_reset();
    issue(OP_GETID, 1, 0, 0, 0, 0);
    @(negedge clk);
    st_ready = 0; ins_valid = 1; ins_data = pack(OP_STORE, 0, 1, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10", "stalled ready", ins_ready, 0);
      chk("R10", "stalled valid", st_valid, {N{1'b1}});
      @(negedge clk);
    end
    st_ready = 1; #1;
    chk("R10", "released ready", ins_ready, 1);
    chk("R10", "store data pe3", int'(st_data[3*DW +: DW]), 3);
    @(negedge clk);
    st_ready = 0; ins_data = pack(OP_ADDI, 2, 1, 0, 1, 0); #1;
    chk("R10", "non-store ready", ins_ready, 1);
    chk("R10", "non-store no valid", st_valid, 0);
    @(posedge clk); #1;
    ins_valid = 0; st_ready = 1;

    // R11: all-reduce
    do_reset();
    issue(OP_GETID, 1, 0, 0, 0, 0);
    issue(OP_ADDI, 1, 1, 0, 1, 0);
    allreduce();
    grab(2);
    for (int i = 0; i < N; i++) chk("R11", "sum 1..N", gd[i], N * (N + 1) / 2);
    issue(OP_GETID, 1, 0, 0, 0, 0);
    issue(OP_MOV, 3, 1, 0, 0, 0);
    issue(OP_ADD, 1, 1, 1, 0, 0);
    issue(OP_ADD, 1, 1, 3, 0, 0);
    issue(OP_ADDI, 1, 1, 0, 200, 0);
    allreduce();
    sum = 3 * N * (N - 1) / 2 + 200 * N;
    grab(2);
    for (int i = 0; i < N; i++) chk("R11", "sum 3i+200", gd[i], sum);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule